// File: doc/BRIEF.md
# MSB Segment Shuffler for a Unary DAC Cell Bank

This block turns the upper (unary) part of each DAC sample into enable lines for a bank of 64 current cells. The bank is split into four segments of 16 cells. For any code the same number of cells is switched on. The shuffling decides which segment supplies which part of the thermometer fill. As a result, the mismatch between segments is spread over time and does not follow the signal level.

The fill order of the four segments is called the permutation. While shuffling is enabled, a new permutation is chosen after a programmable number of sample updates (4, 8 or 16). The choice comes from a 16-bit pseudo-random shift register. While shuffling is disabled, the order stays fixed at the identity. The cell enables are registered, and they change only on a sample update strobe.

Top module: `msb_seg_scrambler`

## Requirements
- R1: After a cycle with `upd` high, `cell_en` has exactly as many ones as the `code` sampled in that cycle (0 to 63).
- R2: `cell_en` bit `g*16+j` drives cell j of segment g. The fill takes whole segments in permutation order: slot 0 takes codes 0..15, slot 1 takes 16..31, and so on. Within a segment the cells fill from j=0 upward.
- R3: In a cycle after one with `upd` low, `cell_en` keeps its previous value.
- R4: `intv_sel` gives the interval: 00 = 4 updates, 01 = 8 updates, 10 and 11 = 16 updates. While shuffling is enabled, the strobe that completes an interval loads a new permutation. That new permutation also maps the sample of that same strobe.
- R5: The generator is a 16-bit shift register. It shifts left, and bit 0 takes the XOR of bits 15, 13, 12 and 10. It advances once per completed interval. The new permutation is the lexicographic permutation of (0,1,2,3) with index (low 8 bits of the advanced state) mod 24. Index 0 is the identity order.
- R6: While `shuf_en` is low, the identity order (segment 0 in slot 0, through segment 3 in slot 3) maps every strobe. The update count is held at zero and the generator state is held. After re-enabling, a full interval passes before the next change.
- R7: Synchronous reset clears `cell_en`, selects the identity order, clears the update count and loads the seed 16'hACE1.
- R8: The active order always names each of the four segments exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shuf_en | input | 1 | Shuffle enable; low forces the identity order |
| upd | input | 1 | Per-sample update strobe |
| intv_sel | input | 2 | Shuffle interval select |
| code | input | 6 | Unary part of the sample (cell count) |
| cell_en | output | 64 | Registered cell enables, segment-major |

## Verification
A strobe in cycle n shows its effect on `cell_en` after the edge that ends cycle n. That is one register stage. A new permutation loaded by a wrapping strobe is already visible in that same output. The bench drives the inputs just after an edge. Its reference model computes the expected next state from those inputs. It then compares `cell_en` one time unit after the following edge. It does this on every cycle, including cycles without a strobe, so that the hold behaviour is checked too.

// File: rtl/segshuf_pkg.sv
package segshuf_pkg;

  localparam int SEGS   = 4;
  localparam int LFSR_W = 16;

  typedef logic [1:0] seg_id_t;
  typedef seg_id_t [SEGS-1:0] seg_order_t;

  localparam seg_order_t ORDER_IDENT = {2'd3, 2'd2, 2'd1, 2'd0};

  // One left shift of the maximal-length register, taps 16,14,13,11.
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] v);
    logic fb;
    fb = v[15] ^ v[13] ^ v[12] ^ v[10];
    return {v[LFSR_W-2:0], fb};
  endfunction

  // Number of updates per shuffle interval.
  function automatic logic [4:0] interval_len(input logic [1:0] sel);
    case (sel)
      2'b00:   return 5'd4;
      2'b01:   return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

  // Decode a lexicographic index (0..23) into an ordering of four segments.
  function automatic seg_order_t order_from_index(input logic [4:0] idx);
    seg_order_t o;
    logic [3:0] used;
    int digit [SEGS];
    int rank;
    logic hit;
    digit[0] = int'(idx) / 6;
    digit[1] = (int'(idx) % 6) / 2;
    digit[2] = int'(idx) % 2;
    digit[3] = 0;
    used = '0;
    o = ORDER_IDENT;
    for (int s = 0; s < SEGS; s++) begin
      rank = 0;
      hit = 1'b0;
      for (int g = 0; g < SEGS; g++) begin
        if (!used[g] && !hit) begin
          if (rank == digit[s]) begin
            o[s] = seg_id_t'(g);
            used[g] = 1'b1;
            hit = 1'b1;
          end
          rank++;
        end
      end
    end
    return o;
  endfunction

  // Reduce generator bits to a permutation index.
  function automatic logic [4:0] index_from_state(input logic [LFSR_W-1:0] st);
    logic [7:0] m;
    m = st[7:0] % 8'd24;
    return m[4:0];
  endfunction

endpackage

// File: rtl/segshuf_lfsr.sv
module segshuf_lfsr
  import segshuf_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [LFSR_W-1:0] state_o,
  output logic [LFSR_W-1:0] next_o
);

  logic [LFSR_W-1:0] st_q;

  assign next_o  = lfsr_step(st_q);
  assign state_o = st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= SEED;
    end else if (adv) begin
      st_q <= next_o;
    end
  end

endmodule

// File: rtl/segshuf_ivl_counter.sv
module segshuf_ivl_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             wrap_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last   = limit - CNT_W'(1);
  assign wrap_o = tick && (cnt_q >= last);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= wrap_o ? '0 : cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/segshuf_therm_map.sv
module segshuf_therm_map
  import segshuf_pkg::*;
#(
  parameter int SEG_CELLS = 16,
  localparam int N_CELLS = SEGS * SEG_CELLS,
  localparam int CODE_W  = $clog2(N_CELLS),
  localparam int FILL_W  = $clog2(SEG_CELLS + 1)
) (
  input  logic [CODE_W-1:0]  code,
  input  seg_order_t         order,
  output logic [N_CELLS-1:0] cells
);

  logic [FILL_W-1:0] slot_fill [SEGS];
  logic [FILL_W-1:0] seg_fill  [SEGS];

  // Cells taken by each slot of the fill sequence.
  always_comb begin
    int cv;
    int base;
    cv = int'(code);
    for (int s = 0; s < SEGS; s++) begin
      base = s * SEG_CELLS;
      if (cv <= base) begin
        slot_fill[s] = '0;
      end else if (cv >= base + SEG_CELLS) begin
        slot_fill[s] = FILL_W'(SEG_CELLS);
      end else begin
        slot_fill[s] = FILL_W'(cv - base);
      end
    end
  end

  // Route each slot's count to the segment that occupies it.
  always_comb begin
    for (int g = 0; g < SEGS; g++) seg_fill[g] = '0;
    for (int s = 0; s < SEGS; s++) seg_fill[order[s]] = slot_fill[s];
  end

  for (genvar g = 0; g < SEGS; g++) begin : g_seg
    for (genvar j = 0; j < SEG_CELLS; j++) begin : g_cell
      assign cells[g*SEG_CELLS + j] = (seg_fill[g] > FILL_W'(j));
    end
  end

endmodule

// File: rtl/msb_seg_scrambler.sv
module msb_seg_scrambler
  import segshuf_pkg::*;
#(
  parameter int SEG_CELLS = 16,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  localparam int N_CELLS = SEGS * SEG_CELLS,
  localparam int CODE_W  = $clog2(N_CELLS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shuf_en,
  input  logic               upd,
  input  logic [1:0]         intv_sel,
  input  logic [CODE_W-1:0]  code,
  output logic [N_CELLS-1:0] cell_en
);

  localparam int CNT_W = 5;

  logic [LFSR_W-1:0]  lfsr_q;
  logic [LFSR_W-1:0]  lfsr_nxt;
  logic               wrap;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   limit;
  seg_order_t         order_q;
  seg_order_t         order_new;
  seg_order_t         order_use;
  logic [N_CELLS-1:0] map_cells;

  assign limit = interval_len(intv_sel);

  segshuf_ivl_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .clr    (!shuf_en),
    .tick   (upd && shuf_en),
    .limit  (limit),
    .wrap_o (wrap),
    .cnt_o  (cnt_q)
  );

  segshuf_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
    .clk     (clk),
    .rst     (rst),
    .adv     (wrap),
    .state_o (lfsr_q),
    .next_o  (lfsr_nxt)
  );

  assign order_new = order_from_index(index_from_state(lfsr_nxt));
  assign order_use = !shuf_en ? ORDER_IDENT : (wrap ? order_new : order_q);

  segshuf_therm_map #(.SEG_CELLS(SEG_CELLS)) u_map (
    .code  (code),
    .order (order_use),
    .cells (map_cells)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      order_q <= ORDER_IDENT;
      cell_en <= '0;
    end else begin
      if (!shuf_en) begin
        order_q <= ORDER_IDENT;
      end else if (wrap) begin
        order_q <= order_new;
      end
      if (upd) begin
        cell_en <= map_cells;
      end
    end
  end

endmodule

// File: rtl/segshuf_checker.sv
module segshuf_checker
  import segshuf_pkg::*;
#(
  parameter int N_CELLS = 64,
  parameter int CODE_W  = 6,
  parameter int CNT_W   = 5,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input logic               clk,
  input logic               rst,
  input logic               shuf_en,
  input logic               upd,
  input logic [CODE_W-1:0]  code,
  input logic [N_CELLS-1:0] cell_en,
  input logic               wrap,
  input logic [CNT_W-1:0]   cnt_q,
  input logic [LFSR_W-1:0]  lfsr_q,
  input seg_order_t         order_q
);

  logic [SEGS-1:0] seen;
  always_comb begin
    seen = '0;
    for (int s = 0; s < SEGS; s++) seen[order_q[s]] = 1'b1;
  end

  p_count_r1: assert property (@(posedge clk) disable iff (rst)
    upd |=> ($countones(cell_en) == int'($past(code))));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(cell_en));

  p_wrap_on_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    wrap |-> (upd && shuf_en));

  p_order_steady_r4: assert property (@(posedge clk) disable iff (rst)
    (shuf_en && !wrap) |=> $stable(order_q));

  p_gen_steady_r5: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(lfsr_q));

  p_disabled_r6: assert property (@(posedge clk) disable iff (rst)
    !shuf_en |=> (order_q == ORDER_IDENT && cnt_q == '0));

  p_reset_r7: assert property (@(posedge clk)
    rst |=> (cell_en == '0 && cnt_q == '0 && lfsr_q == SEED && order_q == ORDER_IDENT));

  p_perm_r8: assert property (@(posedge clk) disable iff (rst)
    seen == 4'b1111);

endmodule

bind msb_seg_scrambler segshuf_checker #(
  .N_CELLS (N_CELLS),
  .CODE_W  (CODE_W),
  .CNT_W   (CNT_W),
  .SEED    (LFSR_SEED)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .shuf_en (shuf_en),
  .upd     (upd),
  .code    (code),
  .cell_en (cell_en),
  .wrap    (wrap),
  .cnt_q   (cnt_q),
  .lfsr_q  (lfsr_q),
  .order_q (order_q)
);

// File: tb/sim_msb_seg_scrambler.sv
module sim_msb_seg_scrambler;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        shuf_en = 1'b0;
  logic        upd = 1'b0;
  logic [1:0]  intv_sel = 2'b00;
  logic [5:0]  code = 6'd0;
  logic [63:0] cell_en;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  msb_seg_scrambler u0 (
    .clk(clk), .rst(rst), .shuf_en(shuf_en), .upd(upd),
    .intv_sel(intv_sel), .code(code), .cell_en(cell_en)
  );

  // Reference model state
  int          m_cnt;
  int          m_lfsr;
  int          m_ord [4];
  logic [63:0] m_out;
  int          n_changes;

  function automatic int next_gen(input int v);
    int fb;
    fb = ((v >> 15) ^ (v >> 13) ^ (v >> 12) ^ (v >> 10)) & 1;
    return ((v << 1) | fb) & 16'hFFFF;
  endfunction

  task automatic lex_order(input int idx, output int o [4]);
    int k;
    k = 0;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++)
            if (a != b && a != c && a != d && b != c && b != d && c != d) begin
              if (k == idx) begin o[0] = a; o[1] = b; o[2] = c; o[3] = d; end
              k++;
            end
  endtask

  function automatic logic [63:0] fill(input int c, input int o [4]);
    logic [63:0] r;
    r = '0;
    for (int n = 0; n < c; n++) r[o[n/16]*16 + n%16] = 1'b1;
    return r;
  endfunction

  task automatic model_edge();
    int lim;
    int nw [4];
    if (rst) begin
      m_cnt = 0; m_lfsr = 16'hACE1; m_out = '0;
      for (int i = 0; i < 4; i++) m_ord[i] = i;
    end else if (!shuf_en) begin
      m_cnt = 0;
      for (int i = 0; i < 4; i++) m_ord[i] = i;
      if (upd) m_out = fill(int'(code), m_ord);
    end else if (upd) begin
      lim = (intv_sel == 2'b00) ? 4 : (intv_sel == 2'b01) ? 8 : 16;
      if (m_cnt >= lim - 1) begin
        m_cnt = 0;
        m_lfsr = next_gen(m_lfsr);
        lex_order((m_lfsr & 255) % 24, nw);
        if (nw != m_ord) n_changes++;
        m_ord = nw;
      end else begin
        m_cnt++;
      end
      m_out = fill(int'(code), m_ord);
    end
  endtask

  task automatic step(input string tag, input logic u, input logic [5:0] c);
    upd = u;
    code = c;
    model_edge();
    @(posedge clk);
    #1;
    checks++;
    if (cell_en !== m_out) begin
      failures++;
      $display("FAIL %s: cell_en actual=%h expected=%h", tag, cell_en, m_out);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog: actual cycles=%0d expected below 150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1;
    n_changes = 0;
    // R7: reset state
    rst = 1'b1;
    repeat (3) step("R7", 1'b0, 6'd0);
    step("R7", 1'b1, 6'd40);
    rst = 1'b0;
    shuf_en = 1'b1;
    // R1 R2 R4: 4-update interval, boundary codes
    intv_sel = 2'b00;
    step("R2", 1'b1, 6'd0);
    step("R2", 1'b1, 6'd1);
    step("R2", 1'b1, 6'd15);
    step("R2", 1'b1, 6'd16);
    step("R2", 1'b1, 6'd17);
    step("R2", 1'b1, 6'd31);
    step("R2", 1'b1, 6'd32);
    step("R2", 1'b1, 6'd48);
    step("R2", 1'b1, 6'd63);
    for (int i = 0; i < 64; i++) step("R1", 1'b1, 6'(i));
    // R3: sparse strobes, outputs hold between them
    for (int i = 0; i < 30; i++) begin
      step("R3", 1'b1, 6'($urandom_range(0, 63)));
      step("R3", 1'b0, 6'($urandom_range(0, 63)));
      step("R3", 1'b0, 6'd63);
    end
    // R4: other interval settings
    intv_sel = 2'b01;
    for (int i = 0; i < 50; i++) step("R4", 1'b1, 6'($urandom_range(0, 63)));
    intv_sel = 2'b10;
    for (int i = 0; i < 70; i++) step("R4", 1'b1, 6'($urandom_range(0, 63)));
    intv_sel = 2'b11;
    for (int i = 0; i < 70; i++) step("R4", 1'b1, 6'($urandom_range(0, 63)));
    // R5: long run at the shortest interval walks the generator
    intv_sel = 2'b00;
    for (int i = 0; i < 400; i++) step("R5", (i % 5) != 4, 6'($urandom_range(0, 63)));
    checks++;
    if (n_changes < 20) begin
      failures++;
      $display("FAIL R5: order changes actual=%0d expected>=20", n_changes);
    end
    // R6: disable mid-interval, then re-enable
    step("R6", 1'b1, 6'd20);
    shuf_en = 1'b0;
    for (int i = 0; i < 12; i++) step("R6", 1'b1, 6'($urandom_range(0, 63)));
    step("R6", 1'b0, 6'd5);
    shuf_en = 1'b1;
    for (int i = 0; i < 20; i++) step("R6", 1'b1, 6'($urandom_range(0, 63)));
    // R7: reset in the middle of a run
    intv_sel = 2'b01;
    for (int i = 0; i < 5; i++) step("R7", 1'b1, 6'(i * 9));
    rst = 1'b1;
    step("R7", 1'b1, 6'd33);
    rst = 1'b0;
    for (int i = 0; i < 40; i++) step("R7", 1'b1, 6'($urandom_range(0, 63)));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule